// File: doc/BRIEF.md
# Latchable Bidirectional Parity Transceiver

This block joins two 8-bit data buses, called side A and side B, each carrying one parity bit next to its data. Two active-low enables choose which side the block drives. Each tri-state pin group is split into an input, an output and an output enable. At any moment the block carries the word in one direction, or in neither. Each side has a transparent latch with its own open control. An open latch follows the pins of its side. A closed latch keeps the last word it took in, and that held word is what the block drives to the far side.

A mode input picks how the outgoing parity bit is formed. In generate mode the parity bit is computed fresh from the eight source data bits. In pass mode the incoming parity bit is copied across unchanged with the data. A second input picks the parity sense, odd or even. Both sides are checked at all times, in both modes, and each side has its own active-low error flag. On the side that receives, the word the block drives is echoed back into that side's check store whenever its latch is open. The receiving side's flag then confirms the word that actually went out.

Each latch captures only words that arrive on its own pins. The driven word goes into a separate echo store that feeds only the checker. The two stores cannot form a loop through the two data paths.

Top module: `latched_parity_xcvr`

## Requirements
- R1: With `en_ab_n`=0 and `en_ba_n`=1 only `b_oe` is 1. With `en_ab_n`=1 and `en_ba_n`=0 only `a_oe` is 1. With both at 1 neither output enable is set.
- R2: With both `en_ab_n` and `en_ba_n` at 0, `clash` is 1 and both `a_oe` and `b_oe` are 0. In every other combination `clash` is 0.
- R3: In generate mode (`pass_par`=0) the driven parity bit makes the count of ones over the 8 driven data bits plus that bit odd when `odd_par`=1 and even when `odd_par`=0.
- R4: In pass mode (`pass_par`=1) the driven parity bit equals the parity bit held in the source side's latch.
- R5: The driven data bits equal the data bits held in the source side's latch.
- R6: While `open_a` (or `open_b`) is 1, that side's latch follows its pins. While it is 0, the latch keeps its last word, and that word keeps being driven and checked even when the pins change.
- R7: A side's latch never takes in a word while the block drives that side. After a turnaround, the side drives out the last word it received from its own pins.
- R8: `err_a_n` (or `err_b_n`) is 0 exactly when the word checked for that side breaks the selected parity sense. On a side that is not driven, the checked word is the latch content.
- R9: While a side is driven and its latch is open, the driven word is echoed into that side's check store and becomes the checked word. When the latch then closes, the echo stays the checked word until the latch reopens.
- R10: In pass mode a parity error on the source word is flagged on both sides once it has been echoed. In generate mode only the source side flags it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| en_ab_n | input | 1 | Active-low enable, drive side B from side A |
| en_ba_n | input | 1 | Active-low enable, drive side A from side B |
| pass_par | input | 1 | 1: copy parity through, 0: generate parity |
| odd_par | input | 1 | 1: odd parity sense, 0: even |
| open_a | input | 1 | Side A latch open (transparent) when 1 |
| open_b | input | 1 | Side B latch open (transparent) when 1 |
| a_in | input | 8 | Side A data pins, input path |
| a_par_in | input | 1 | Side A parity pin, input path |
| a_out | output | 8 | Side A data pins, output path |
| a_par_out | output | 1 | Side A parity pin, output path |
| a_oe | output | 1 | Side A pin output enable |
| b_in | input | 8 | Side B data pins, input path |
| b_par_in | input | 1 | Side B parity pin, input path |
| b_out | output | 8 | Side B data pins, output path |
| b_par_out | output | 1 | Side B parity pin, output path |
| b_oe | output | 1 | Side B pin output enable |
| err_a_n | output | 1 | Side A parity error, low on mismatch |
| err_b_n | output | 1 | Side B parity error, low on mismatch |
| clash | output | 1 | Both enables low, illegal request |

## Verification
The block has no clock, so every result is due in the same cycle as the stimulus that causes it. Enables, driven data, parity and both error flags settle through latches and gates with no register in the path. The bench changes inputs only on the falling clock edge and reads outputs one nanosecond later. Its reference model updates its latch, echo and error state in the order the signals flow: source capture, then forming the driven word, then echo capture, then the checks. Because of this, the values compared are the ones due after that single set of inputs.

// File: rtl/pxcv_pkg.sv
package pxcv_pkg;

  // Widest data word the parity helpers accept; narrower words are zero-extended,
  // which leaves their parity unchanged.
  localparam int unsigned MAX_DW = 64;
  typedef logic [MAX_DW-1:0] wide_t;

  typedef enum logic [1:0] {
    DIR_IDLE  = 2'b00,
    DIR_AB    = 2'b01,
    DIR_BA    = 2'b10,
    DIR_CLASH = 2'b11
  } dir_e;

  // Parity bit that brings the word plus itself to the requested sense.
  function automatic logic fill_bit(input wide_t data, input logic odd);
    return (^data) ^ odd;
  endfunction

  // True when data plus parity bit meet the requested sense.
  function automatic logic word_ok(input wide_t data, input logic par, input logic odd);
    return ((^data) ^ par) == odd;
  endfunction

endpackage

// File: rtl/pxcv_dir_ctrl.sv
module pxcv_dir_ctrl
  import pxcv_pkg::*;
(
  input  logic en_ab_n,
  input  logic en_ba_n,
  output logic drive_a,
  output logic drive_b,
  output logic clash
);

  dir_e dir;

  always_comb begin
    unique case ({~en_ba_n, ~en_ab_n})
      2'b01:   dir = DIR_AB;
      2'b10:   dir = DIR_BA;
      2'b11:   dir = DIR_CLASH;
      default: dir = DIR_IDLE;
    endcase
  end

  // A clash drives nothing: both directions are dropped.
  assign drive_b = (dir == DIR_AB);
  assign drive_a = (dir == DIR_BA);
  assign clash   = (dir == DIR_CLASH);

endmodule

// File: rtl/pxcv_side_latch.sv
module pxcv_side_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          open_en,
  input  logic          driven,
  input  logic [DW-1:0] pad_d,
  input  logic          pad_p,
  input  logic [DW-1:0] echo_d,
  input  logic          echo_p,
  output logic [DW-1:0] src_d,
  output logic          src_p,
  output logic [DW-1:0] chk_d,
  output logic          chk_p
);

  localparam int unsigned WW = DW + 1;

  logic [WW-1:0] src_q;
  logic [WW-1:0] echo_q;
  logic          use_echo_q;

  // Source store: takes in only words that arrive on this side's own pins.
  always_latch begin
    if (open_en && !driven) src_q <= {pad_p, pad_d};
  end

  // Echo store: holds the word driven onto this side, for the checker only.
  always_latch begin
    if (open_en) begin
      use_echo_q <= driven;
      if (driven) echo_q <= {echo_p, echo_d};
    end
  end

  assign src_d = src_q[DW-1:0];
  assign src_p = src_q[DW];
  assign chk_d = use_echo_q ? echo_q[DW-1:0] : src_q[DW-1:0];
  assign chk_p = use_echo_q ? echo_q[DW]     : src_q[DW];

endmodule

// File: rtl/pxcv_xfer_path.sv
module pxcv_xfer_path
  import pxcv_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] src_d,
  input  logic          src_p,
  input  logic          pass_par,
  input  logic          odd_par,
  output logic [DW-1:0] out_d,
  output logic          out_p
);

  logic fresh_p;

  assign fresh_p = fill_bit(wide_t'(src_d), odd_par);
  assign out_d   = src_d;
  assign out_p   = pass_par ? src_p : fresh_p;

endmodule

// File: rtl/pxcv_par_mon.sv
module pxcv_par_mon
  import pxcv_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] chk_d,
  input  logic          chk_p,
  input  logic          odd_par,
  output logic          err_n
);

  assign err_n = word_ok(wide_t'(chk_d), chk_p, odd_par);

endmodule

// File: rtl/latched_parity_xcvr.sv
module latched_parity_xcvr #(
  parameter int unsigned DW = 8
) (
  input  logic          en_ab_n,
  input  logic          en_ba_n,
  input  logic          pass_par,
  input  logic          odd_par,
  input  logic          open_a,
  input  logic          open_b,
  input  logic [DW-1:0] a_in,
  input  logic          a_par_in,
  output logic [DW-1:0] a_out,
  output logic          a_par_out,
  output logic          a_oe,
  input  logic [DW-1:0] b_in,
  input  logic          b_par_in,
  output logic [DW-1:0] b_out,
  output logic          b_par_out,
  output logic          b_oe,
  output logic          err_a_n,
  output logic          err_b_n,
  output logic          clash
);

  logic          drive_a, drive_b;
  logic [DW-1:0] src_a_d, src_b_d, chk_a_d, chk_b_d;
  logic          src_a_p, src_b_p, chk_a_p, chk_b_p;
  logic [DW-1:0] to_a_d, to_b_d;
  logic          to_a_p, to_b_p;

  pxcv_dir_ctrl u_dir (
    .en_ab_n (en_ab_n),
    .en_ba_n (en_ba_n),
    .drive_a (drive_a),
    .drive_b (drive_b),
    .clash   (clash)
  );

  pxcv_side_latch #(.DW(DW)) u_lat_a (
    .open_en (open_a),
    .driven  (drive_a),
    .pad_d   (a_in),
    .pad_p   (a_par_in),
    .echo_d  (to_a_d),
    .echo_p  (to_a_p),
    .src_d   (src_a_d),
    .src_p   (src_a_p),
    .chk_d   (chk_a_d),
    .chk_p   (chk_a_p)
  );

  pxcv_side_latch #(.DW(DW)) u_lat_b (
    .open_en (open_b),
    .driven  (drive_b),
    .pad_d   (b_in),
    .pad_p   (b_par_in),
    .echo_d  (to_b_d),
    .echo_p  (to_b_p),
    .src_d   (src_b_d),
    .src_p   (src_b_p),
    .chk_d   (chk_b_d),
    .chk_p   (chk_b_p)
  );

  pxcv_xfer_path #(.DW(DW)) u_ab (
    .src_d    (src_a_d),
    .src_p    (src_a_p),
    .pass_par (pass_par),
    .odd_par  (odd_par),
    .out_d    (to_b_d),
    .out_p    (to_b_p)
  );

  pxcv_xfer_path #(.DW(DW)) u_ba (
    .src_d    (src_b_d),
    .src_p    (src_b_p),
    .pass_par (pass_par),
    .odd_par  (odd_par),
    .out_d    (to_a_d),
    .out_p    (to_a_p)
  );

  pxcv_par_mon #(.DW(DW)) u_mon_a (
    .chk_d   (chk_a_d),
    .chk_p   (chk_a_p),
    .odd_par (odd_par),
    .err_n   (err_a_n)
  );

  pxcv_par_mon #(.DW(DW)) u_mon_b (
    .chk_d   (chk_b_d),
    .chk_p   (chk_b_p),
    .odd_par (odd_par),
    .err_n   (err_b_n)
  );

  assign a_out     = to_a_d;
  assign a_par_out = to_a_p;
  assign a_oe      = drive_a;
  assign b_out     = to_b_d;
  assign b_par_out = to_b_p;
  assign b_oe      = drive_b;

endmodule

// File: rtl/pxcv_checker.sv
module pxcv_checker #(
  parameter int unsigned DW = 8
) (
  input logic          en_ab_n,
  input logic          en_ba_n,
  input logic          pass_par,
  input logic          odd_par,
  input logic          open_a,
  input logic          open_b,
  input logic [DW-1:0] a_in,
  input logic          a_par_in,
  input logic [DW-1:0] a_out,
  input logic          a_par_out,
  input logic          a_oe,
  input logic [DW-1:0] b_in,
  input logic          b_par_in,
  input logic [DW-1:0] b_out,
  input logic          b_par_out,
  input logic          b_oe,
  input logic          err_a_n,
  input logic          err_b_n,
  input logic          clash
);

  always_comb begin
    // R1: never both pin groups driven
    a_r1_one_side: assert (!(a_oe && b_oe))
      else $error("both sides driven");
    // R2: clash request drives nothing
    a_r2_clash_quiet: assert (!clash || (!a_oe && !b_oe && !en_ab_n && !en_ba_n))
      else $error("clash with a side driven");
    // R3: generated parity meets the sense on whichever side is driven
    a_r3_fresh_b: assert (!(b_oe && !pass_par) || ((^{b_out, b_par_out}) == odd_par))
      else $error("generated parity wrong on B");
    a_r3_fresh_a: assert (!(a_oe && !pass_par) || ((^{a_out, a_par_out}) == odd_par))
      else $error("generated parity wrong on A");
    // R4/R5: open source latch in pass mode is a straight wire
    a_r4_pass_ab: assert (!(b_oe && pass_par && open_a) || ({b_par_out, b_out} == {a_par_in, a_in}))
      else $error("pass word A to B differs");
    a_r4_pass_ba: assert (!(a_oe && pass_par && open_b) || ({a_par_out, a_out} == {b_par_in, b_in}))
      else $error("pass word B to A differs");
    // R8: undriven open side checks its own pins
    a_r8_pins_a: assert (!(!a_oe && open_a) || (err_a_n == ((^{a_in, a_par_in}) == odd_par)))
      else $error("side A flag disagrees with pins");
    a_r8_pins_b: assert (!(!b_oe && open_b) || (err_b_n == ((^{b_in, b_par_in}) == odd_par)))
      else $error("side B flag disagrees with pins");
    // R9: an echoed generated word is always clean
    a_r9_echo_clean_b: assert (!(b_oe && open_b && !pass_par) || err_b_n)
      else $error("echo of generated word flagged on B");
    a_r9_echo_clean_a: assert (!(a_oe && open_a && !pass_par) || err_a_n)
      else $error("echo of generated word flagged on A");
    // R10: in pass mode with both latches open both flags agree
    a_r10_pass_both: assert (!((a_oe || b_oe) && pass_par && open_a && open_b) || (err_a_n == err_b_n))
      else $error("flags disagree in pass mode");
  end

endmodule

bind latched_parity_xcvr pxcv_checker #(.DW(DW)) u_chk (
  .en_ab_n   (en_ab_n),
  .en_ba_n   (en_ba_n),
  .pass_par  (pass_par),
  .odd_par   (odd_par),
  .open_a    (open_a),
  .open_b    (open_b),
  .a_in      (a_in),
  .a_par_in  (a_par_in),
  .a_out     (a_out),
  .a_par_out (a_par_out),
  .a_oe      (a_oe),
  .b_in      (b_in),
  .b_par_in  (b_par_in),
  .b_out     (b_out),
  .b_par_out (b_par_out),
  .b_oe      (b_oe),
  .err_a_n   (err_a_n),
  .err_b_n   (err_b_n),
  .clash     (clash)
);

// File: tb/test_latched_parity_xcvr.sv
module test_latched_parity_xcvr;

  localparam int DW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          en_ab_n = 1'b1, en_ba_n = 1'b1, pass_par = 1'b0, odd_par = 1'b0;
  logic          open_a = 1'b1, open_b = 1'b1;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic          a_par_in = 1'b0, b_par_in = 1'b0;
  logic [DW-1:0] a_out, b_out;
  logic          a_par_out, b_par_out, a_oe, b_oe, err_a_n, err_b_n, clash;

  latched_parity_xcvr #(.DW(DW)) i_latched_parity_xcvr (
    .en_ab_n(en_ab_n), .en_ba_n(en_ba_n), .pass_par(pass_par), .odd_par(odd_par),
    .open_a(open_a), .open_b(open_b),
    .a_in(a_in), .a_par_in(a_par_in), .a_out(a_out), .a_par_out(a_par_out), .a_oe(a_oe),
    .b_in(b_in), .b_par_in(b_par_in), .b_out(b_out), .b_par_out(b_par_out), .b_oe(b_oe),
    .err_a_n(err_a_n), .err_b_n(err_b_n), .clash(clash)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // Reference state: {parity, data}
  logic [DW:0] m_src_a = '0, m_src_b = '0, m_echo_a = '0, m_echo_b = '0;
  logic        m_fe_a = 1'b0, m_fe_b = 1'b0;

  function automatic int ones(input logic [DW:0] w);
    int c = 0;
    for (int i = 0; i <= DW; i++) c += int'(w[i]);
    return c;
  endfunction

  // Word as driven from a held source word.
  function automatic logic [DW:0] sent(input logic [DW:0] src, input logic pass, input logic odd);
    logic [DW:0] w;
    w = {1'b0, src[DW-1:0]};
    if (pass) return src;
    w[DW] = ((ones(w) % 2) == 1) ? !odd : odd;
    return w;
  endfunction

  function automatic logic clean(input logic [DW:0] w, input logic odd);
    return (ones(w) % 2) == int'(odd);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input logic eab, input logic eba, input logic pass, input logic odd,
                       input logic la, input logic lb,
                       input logic [DW:0] aw, input logic [DW:0] bw);
    logic drv_a, drv_b;
    logic [DW:0] to_a, to_b, view_a, view_b;
    @(negedge clk);
    en_ab_n = eab; en_ba_n = eba; pass_par = pass; odd_par = odd;
    open_a = la; open_b = lb;
    {a_par_in, a_in} = aw; {b_par_in, b_in} = bw;
    drv_b = !eab && eba;
    drv_a = eab && !eba;
    if (la && !drv_a) m_src_a = aw;
    if (lb && !drv_b) m_src_b = bw;
    to_b = sent(m_src_a, pass, odd);
    to_a = sent(m_src_b, pass, odd);
    if (la) begin m_fe_a = drv_a; if (drv_a) m_echo_a = to_a; end
    if (lb) begin m_fe_b = drv_b; if (drv_b) m_echo_b = to_b; end
    view_a = m_fe_a ? m_echo_a : m_src_a;
    view_b = m_fe_b ? m_echo_b : m_src_b;
    #1;
    chk("R1 a_oe", 32'(a_oe), 32'(drv_a));
    chk("R1 b_oe", 32'(b_oe), 32'(drv_b));
    chk("R2 clash", 32'(clash), 32'(!eab && !eba));
    if (drv_b) begin
      chk("R5/R6/R7 b_out", 32'(b_out), 32'(to_b[DW-1:0]));
      chk(pass ? "R4 b_par_out" : "R3 b_par_out", 32'(b_par_out), 32'(to_b[DW]));
    end
    if (drv_a) begin
      chk("R5/R6/R7 a_out", 32'(a_out), 32'(to_a[DW-1:0]));
      chk(pass ? "R4 a_par_out" : "R3 a_par_out", 32'(a_par_out), 32'(to_a[DW]));
    end
    chk(m_fe_a ? "R9/R10 err_a_n" : "R8 err_a_n", 32'(err_a_n), 32'(clean(view_a, odd)));
    chk(m_fe_b ? "R9/R10 err_b_n" : "R8 err_b_n", 32'(err_b_n), 32'(clean(view_b, odd)));
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    // Idle load, both latches open: first state checks
    apply(1, 1, 0, 0, 1, 1, 9'h0_5A, 9'h1_3C);
    // R2 clash
    apply(0, 0, 0, 1, 1, 1, 9'h0_11, 9'h0_22);
    // R3 generate A to B, even and odd, clean source
    apply(0, 1, 0, 0, 1, 1, 9'h0_81, 9'h0_00);
    apply(0, 1, 0, 1, 1, 1, 9'h0_07, 9'h0_00);
    // R10 single-bit error on source: generate (only A flags), pass (both flag)
    apply(0, 1, 0, 0, 1, 1, 9'h1_81, 9'h0_00);
    apply(0, 1, 1, 0, 1, 1, 9'h1_81, 9'h0_00);
    // R6 hold A, change pins, B keeps old word
    apply(0, 1, 1, 0, 0, 1, 9'h0_FF, 9'h0_00);
    // R9 close B after echo: echo stays checked word
    apply(0, 1, 1, 0, 0, 0, 9'h1_00, 9'h1_01);
    // R7 turnaround with B closed: drives last word from its own pins
    apply(1, 0, 0, 1, 1, 0, 9'h0_00, 9'h0_33);
    apply(1, 0, 1, 1, 1, 1, 9'h0_00, 9'h1_C3);
    // Random mix of every enable, mode, sense and latch setting
    for (int k = 0; k < 6000; k++) begin
      logic [DW:0] aw, bw;
      logic [2:0] r;
      aw = DW+1'($urandom);
      bw = DW+1'($urandom);
      r = 3'($urandom);
      apply(r[0] | r[2], r[1] | r[2] ? 1'b1 : r[0], 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), aw, bw);
      if (k % 7 == 0) apply(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                            1'($urandom), 1'($urandom), aw, bw);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule